// File: doc/BRIEF.md
# Character-synchronous serial receiver with SYN hunt

This block receives a serial bit stream that has no start or stop bits and recovers character boundaries from the data itself. A one-cycle bit strobe qualifies each incoming bit. After the receiver is enabled, it slides a window over the stream one bit at a time and looks for a programmed synchronisation character. It can also require a second, different synchronisation character immediately afterwards. Once the alignment is confirmed, it cuts the stream into characters of the programmed length, least significant bit first. It delivers each character as a single output beat.

A frame ends on any character that equals one of four programmed end-of-frame codes. That character is delivered with an end flag, and the receiver then returns to hunting for the next frame. The synchronisation characters can be removed from the delivered data or passed through ahead of the frame contents. Character length is 5 to 8 bits, and the unused upper bits of the output byte are zero.

Top module: `syn_char_rx`

## Requirements
- R1: While `rx_en` is low, no beat is produced and any partial character or pending alignment is dropped. Raising `rx_en` starts a fresh hunt.
- R2: In hunt, the low `len` bits of `syn1` are compared with the last `len` received bits after every qualified bit, so alignment is found at any bit offset. No match is accepted before `len` bits have arrived since the hunt began.
- R3: With `dual_syn` low, a `syn1` match starts the frame, and the next `len` bits form the first frame character.
- R4: With `dual_syn` high, the `len` bits after `syn1` are compared with `syn2`. A match starts the frame. A mismatch returns to hunt, and the hunt continues sliding from the bits already received.
- R5: With `strip_syn` high, matched synchronisation characters are never delivered. With it low, they are delivered as ordinary beats ahead of the frame data (`syn1`, then `syn2` in dual mode), masked to `len` bits.
- R6: Frame characters are taken on fixed `len`-bit boundaries, first received bit in bit 0, with bits `len` and above zero. The beat (`out_valid` high for one clock) appears on the clock after the edge that takes the last bit.
- R7: Each frame character is compared with the four codes in `eof_set` (code k in bits 8k+7..8k), masked to `len` bits. On a match with any of them, the character is delivered with `out_eof` high on the same beat.
- R8: After an end-of-frame character, the receiver returns to hunt and needs `len` fresh bits before the next `syn1` match.
- R9: The effective length is `char_len` clamped to the range 5..8. The state advances only on clocks where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low holds the block idle |
| bit_en | input | 1 | Qualifies `rx_bit` for this clock |
| rx_bit | input | 1 | Serial data bit |
| char_len | input | 4 | Bits per character, clamped to 5..8 |
| syn1 | input | 8 | First synchronisation character |
| syn2 | input | 8 | Second synchronisation character |
| dual_syn | input | 1 | Require `syn2` after `syn1` |
| strip_syn | input | 1 | Drop synchronisation characters from the output |
| eof_set | input | 32 | Four end-of-frame codes, code k in bits 8k+7..8k |
| out_valid | output | 1 | One-clock beat carrying a character |
| out_data | output | 8 | Received character, zero above `len` |
| out_eof | output | 1 | Beat carries an end-of-frame character |

## Verification
The bench places junk bits before `syn1` so that the true alignment lies at a different offset each time. A receiver that framed on fixed boundaries during the hunt, or that accepted a match before its window had filled, would produce shifted characters. A second character that is not `syn2` must send the receiver back to hunt. A design that ignored the mismatch would deliver the junk as data. Dropping the enable in the middle of a character must discard the half-received bits, or the next frame comes out misaligned. Masked end-of-frame matching at 5 and 7 bits, back-to-back frames and a clamped `char_len` are also exercised. These catch designs that compare all eight bits, or that stay in the frame after an end-of-frame character.

// File: rtl/syn_char_rx.sv
module syn_char_rx #(
  parameter int W       = 8,
  parameter int NEOF    = 4,
  parameter int MIN_LEN = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_en,
  input  logic                  bit_en,
  input  logic                  rx_bit,
  input  logic [$clog2(W+1)-1:0] char_len,
  input  logic [W-1:0]          syn1,
  input  logic [W-1:0]          syn2,
  input  logic                  dual_syn,
  input  logic                  strip_syn,
  input  logic [NEOF*W-1:0]     eof_set,
  output logic                  out_valid,
  output logic [W-1:0]          out_data,
  output logic                  out_eof
);
  localparam int LW = $clog2(W+1);

  typedef enum logic [1:0] {S_HUNT, S_SYN2, S_FRAME} st_t;

  st_t           st;
  logic [LW-1:0] cnt, len;
  logic [W-1:0]  sh, nxt, win, mask;
  logic          pend, last, filled, syn1_hit, syn2_hit, eof_hit;

  always_comb begin
    if (char_len < LW'(MIN_LEN)) len = LW'(MIN_LEN);
    else if (char_len > LW'(W))  len = LW'(W);
    else                         len = char_len;
  end

  assign mask     = {W{1'b1}} >> (LW'(W) - len);
  assign nxt      = {rx_bit, sh[W-1:1]};
  assign win      = nxt >> (LW'(W) - len);
  assign last     = (cnt == len - 1'b1);
  assign filled   = (cnt >= len - 1'b1);
  assign syn1_hit = (win == (syn1 & mask));
  assign syn2_hit = (win == (syn2 & mask));

  always_comb begin
    eof_hit = 1'b0;
    for (int k = 0; k < NEOF; k++)
      if ((eof_set[k*W +: W] & mask) == win) eof_hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HUNT; cnt <= '0; sh <= '0; pend <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_eof <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      if (!rx_en) begin
        st <= S_HUNT; cnt <= '0; sh <= '0; pend <= 1'b0;
      end else begin
        if (pend) begin
          out_valid <= 1'b1;
          out_data  <= syn2 & mask;
          pend      <= 1'b0;
        end
        if (bit_en) begin
          sh <= nxt;
          case (st)
            S_HUNT:
              if (filled && syn1_hit) begin
                cnt <= '0;
                if (dual_syn) st <= S_SYN2;
                else begin
                  st <= S_FRAME;
                  if (!strip_syn) begin out_valid <= 1'b1; out_data <= win; end
                end
              end else if (!filled) cnt <= cnt + 1'b1;
            S_SYN2:
              if (last) begin
                if (syn2_hit) begin
                  st  <= S_FRAME;
                  cnt <= '0;
                  if (!strip_syn) begin
                    out_valid <= 1'b1;
                    out_data  <= syn1 & mask;
                    pend      <= 1'b1;
                  end
                end else begin
                  st  <= S_HUNT;
                  cnt <= len - 1'b1;
                end
              end else cnt <= cnt + 1'b1;
            default:
              if (last) begin
                out_valid <= 1'b1;
                out_data  <= win;
                out_eof   <= eof_hit;
                cnt       <= '0;
                if (eof_hit) st <= S_HUNT;
              end else cnt <= cnt + 1'b1;
          endcase
        end
      end
    end
  end

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !out_valid);
  a_r3_single_skips_syn2: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_syn |-> st != S_SYN2);
  a_r5_strip_hides_syn: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_syn && st != S_FRAME) |=> !out_valid);
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ~mask) == '0));
  a_r7_eof_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);
  a_r8_eof_rehunt: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> st == S_HUNT);
  a_r9_beat_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(bit_en) || $past(pend)));
endmodule

// File: tb/syn_char_rx_tb.sv
module syn_char_rx_tb_top;
  logic clk = 0, rst_n = 0, rx_en = 0, bit_en = 0, rx_bit = 0;
  logic [3:0]  char_len = 4'd8;
  logic [7:0]  syn1 = 8'h16, syn2 = 8'h2B;
  logic        dual_syn = 0, strip_syn = 1;
  logic [31:0] eof_set = 32'hE4E3E2E1;
  logic        out_valid, out_eof;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  syn_char_rx dut_i (.clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_en(bit_en),
    .rx_bit(rx_bit), .char_len(char_len), .syn1(syn1), .syn2(syn2),
    .dual_syn(dual_syn), .strip_syn(strip_syn), .eof_set(eof_set),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof));

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] cap_d [0:15];
  logic       cap_e [0:15];
  int         cap_n = 0;

  always @(negedge clk)
    if (rst_n && out_valid && cap_n < 16) begin
      cap_d[cap_n] = out_data; cap_e[cap_n] = out_eof; cap_n++;
    end

  typedef struct packed {
    logic [3:0] len; logic [7:0] s1, s2; logic dual, strip; logic [3:0] pre;
    logic [7:0] d0, d1, ec; logic [2:0] n; logic [0:4][7:0] e;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{4'd8, 8'h16, 8'h00, 1'b0, 1'b1, 4'd3, 8'hA5, 8'h3C, 8'hE1, 3'd3, '{8'hA5, 8'h3C, 8'hE1, 8'h00, 8'h00}},
    '{4'd8, 8'h16, 8'h2B, 1'b1, 1'b1, 4'd0, 8'hA5, 8'hC3, 8'hE3, 3'd3, '{8'hA5, 8'hC3, 8'hE3, 8'h00, 8'h00}},
    '{4'd8, 8'h16, 8'h00, 1'b0, 1'b0, 4'd5, 8'h11, 8'h22, 8'hE4, 3'd4, '{8'h16, 8'h11, 8'h22, 8'hE4, 8'h00}},
    '{4'd8, 8'h16, 8'h2B, 1'b1, 1'b0, 4'd2, 8'h55, 8'h66, 8'hE2, 3'd5, '{8'h16, 8'h2B, 8'h55, 8'h66, 8'hE2}},
    '{4'd7, 8'h16, 8'h00, 1'b0, 1'b1, 4'd3, 8'hFF, 8'h80, 8'h61, 3'd3, '{8'h7F, 8'h00, 8'h61, 8'h00, 8'h00}},
    '{4'd5, 8'h16, 8'h0A, 1'b1, 1'b0, 4'd3, 8'h1F, 8'h10, 8'h02, 3'd5, '{8'h16, 8'h0A, 8'h1F, 8'h10, 8'h02}}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int gap = 0;
  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1;
    @(negedge clk); bit_en = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c, input int n);
    for (int i = 0; i < n; i++) send_bit(c[i]);
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic expect_beats(input string req, input int n, input logic [0:4][7:0] e);
    repeat (3) @(negedge clk);
    chk(cap_n == n, {req, " beat count"}, cap_n, n);
    for (int i = 0; i < n && i < cap_n; i++) begin
      chk(cap_d[i] == e[i], {req, " data"}, cap_d[i], e[i]);
      chk(cap_e[i] == (i == n - 1), {req, " eof flag"}, cap_e[i], i == n - 1);
    end
    cap_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset and disabled state
    chk(!out_valid && !out_eof && out_data == 0, "R1 reset outputs", out_valid, 0);
    ones(4);
    send_char(8'h16, 8); send_char(8'hA5, 8);
    chk(cap_n == 0, "R1 no beats while disabled", cap_n, 0);
    rx_en = 1;

    // R2 R3 R5 R6 R7 R9: table walk with varied bit spacing
    for (int v = 0; v < 6; v++) begin
      char_len = VECS[v].len; syn1 = VECS[v].s1; syn2 = VECS[v].s2;
      dual_syn = VECS[v].dual; strip_syn = VECS[v].strip; gap = v % 3;
      cap_n = 0;
      ones(VECS[v].pre);
      send_char(VECS[v].s1, VECS[v].len);
      if (VECS[v].dual) send_char(VECS[v].s2, VECS[v].len);
      send_char(VECS[v].d0, VECS[v].len);
      send_char(VECS[v].d1, VECS[v].len);
      send_char(VECS[v].ec, VECS[v].len);
      ones(10);
      expect_beats("R6 R7 table", VECS[v].n, VECS[v].e);
    end
    gap = 0;

    // R4: syn2 mismatch returns to hunt
    char_len = 8; syn1 = 8'h16; syn2 = 8'h2B; dual_syn = 1; strip_syn = 1;
    ones(10); cap_n = 0;
    send_char(8'h16, 8); send_char(8'h77, 8);
    send_char(8'h16, 8); send_char(8'h2B, 8); send_char(8'h42, 8); send_char(8'hE1, 8);
    ones(4);
    expect_beats("R4 syn2 mismatch", 2, '{8'h42, 8'hE1, 8'h00, 8'h00, 8'h00});

    // R8: back-to-back frames re-hunt
    dual_syn = 0; ones(4); cap_n = 0;
    send_char(8'h16, 8); send_char(8'h5A, 8); send_char(8'hE2, 8);
    send_char(8'h16, 8); send_char(8'h3C, 8); send_char(8'hE3, 8);
    ones(4);
    chk(cap_n == 4, "R8 two frames beat count", cap_n, 4);
    chk(cap_d[1] == 8'hE2 && cap_e[1], "R8 first eof", cap_d[1], 8'hE2);
    chk(cap_d[2] == 8'h3C && !cap_e[2], "R8 second frame data", cap_d[2], 8'h3C);
    chk(cap_d[3] == 8'hE3 && cap_e[3], "R8 second eof", cap_d[3], 8'hE3);
    cap_n = 0;

    // R1: enable drop mid-character discards the partial bits
    send_char(8'h16, 8); send_char(8'hA5, 4);
    rx_en = 0;
    send_char(8'hFF, 3);
    chk(cap_n == 0, "R1 quiet during drop", cap_n, 0);
    rx_en = 1;
    send_char(8'h5A, 4);
    send_char(8'h16, 8); send_char(8'h3C, 8); send_char(8'hE1, 8);
    ones(4);
    expect_beats("R1 re-enable", 2, '{8'h3C, 8'hE1, 8'h00, 8'h00, 8'h00});

    // R2: window must fill before matching an all-zero syn1
    rx_en = 0; syn1 = 8'h00; @(negedge clk); rx_en = 1;
    send_char(8'h00, 8); send_char(8'h5A, 8); send_char(8'hE1, 8);
    ones(4);
    expect_beats("R2 fill before match", 2, '{8'h5A, 8'hE1, 8'h00, 8'h00, 8'h00});

    // R9: char_len below range clamps to 5
    rx_en = 0; syn1 = 8'h16; char_len = 4'd2; @(negedge clk); rx_en = 1;
    ones(3); send_char(8'h16, 5); send_char(8'h1F, 5); send_char(8'h02, 5);
    ones(6);
    expect_beats("R9 length clamp", 2, '{8'h1F, 8'h02, 8'h00, 8'h00, 8'h00});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule